// File: doc/BRIEF.md
# Directory Transactional Conflict Detector

This block is the directory side of a small shared-memory system with transactional execution, plus the per-core transactional read and write sets that answer its queries. A core never talks to another core directly. It sends its read or write request for a line to the directory. The directory looks up the cores that may hold that line and forwards the request to each of them. Every forwarded core compares the request with its own transactional sets and replies with either an acknowledge or a negative acknowledge.

Once every forwarded core has replied, the directory decides. If no core refused, the request is granted and the directory updates the line's sharer record. If any core refused, the requester is told to stall or abort, and nothing in the directory changes.

A core can drop a line from its cache while that line is still in its transactional footprint. In that case the directory marks the core as a sticky holder of the line. The core keeps receiving forwarded requests for the line until it ends its transaction. Data movement and interconnect timing are outside the block. Replies arrive one cycle after forwarding.

Top module: `txn_conflict_dir`

## Requirements
- R1: After reset `req_ready` is 1, `done_valid` and `fwd_valid` are 0, and no line has any sharer, sticky holder or transactional set bit, so a first request is granted with an empty forward mask.
- R2: An accepted request is forwarded for exactly one cycle (`fwd_valid`=1), with `fwd_mask` equal to the line's sharers OR its sticky holders, with the requester's own bit cleared; bit i of `fwd_mask` stands for core i.
- R3: A forwarded write is refused by a core whose transactional read set or write set holds the line. A forwarded read is refused only by a core whose write set holds it. All other replies are acknowledges.
- R4: A request that receives any negative acknowledge completes with `done_grant`=0, and the line's sharers and sticky holders are unchanged; repeating the request produces the same forward mask and the same refusal.
- R5: The decision waits for a reply from every forwarded core. `done_valid` pulses one cycle after the forward cycle when the mask is empty, and two cycles after it otherwise.
- R6: A granted read adds the requester to the line's sharers. A granted write makes the requester the only sharer.
- R7: An eviction (`evict_valid`) removes the core from the line's sharers. If the line is in that core's transactional read or write set, the core becomes a sticky holder and is still forwarded to. Otherwise it is no longer forwarded to.
- R8: A transaction end (`txend_valid`) for a core clears its transactional read and write sets and its sticky holder bit on every line.
- R9: A request is accepted only in a cycle where `req_ready` is 1. `req_ready` is 0 from acceptance until `done_valid` has been seen, and a request held high during that time is ignored.
- R10: A granted access enters the requester's read set (read) or write set (write) only when `req_tx` was 1 with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_core | input | 2 | Requesting core index |
| req_line | input | 3 | Line index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tx | input | 1 | Requester is inside a transaction |
| req_ready | output | 1 | Directory idle, request may be accepted |
| evict_valid | input | 1 | A core drops a line from its cache |
| evict_core | input | 2 | Evicting core |
| evict_line | input | 3 | Evicted line |
| txend_valid | input | 1 | A core commits or aborts its transaction |
| txend_core | input | 2 | Core ending its transaction |
| fwd_valid | output | 1 | Forward cycle of the current request |
| fwd_mask | output | 4 | Cores the request is forwarded to |
| done_valid | output | 1 | Decision pulse |
| done_grant | output | 1 | 1 = granted, 0 = conflict (stall or abort) |
| done_core | output | 2 | Requester the decision belongs to |

## Verification
The bench sweeps every requester and other-core pair through every combination of the other core's footprint (none, read, write) and the operation (read, write). Each case computes the expected forward mask, reply latency and decision. A design that treated read-after-read as a conflict, let a read pass a foreign write set, or forwarded to the requester itself would give a wrong decision or a wrong mask there.

After each refusal the same request is repeated and must give the same result. A design that updated sharers on a refusal would show a changed mask. A granted write is followed by a read that must be forwarded only to the writer.

Directed cases cover three more behaviours:
- An eviction inside a transaction must keep the core forwarded until its transaction ends, while an eviction outside a transaction must drop it. A design without the sticky state would let a conflicting write through.
- A non-transactional write must leave no set bit behind.
- A request held high while the directory is busy must be ignored.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } tcd_state_e;

    // Conflict rule of a forwarded request against one core's sets
    function automatic logic tcd_conflict(input logic is_write,
                                          input logic in_rd,
                                          input logic in_wr);
        return is_write ? (in_rd | in_wr) : in_wr;
    endfunction

endpackage

// File: rtl/tcd_core_sets.sv
module tcd_core_sets
    import tcd_pkg::*;
#(
    parameter int LINES = 8,
    parameter int LW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_hit,
    input  logic             fwd_write,
    input  logic [LW-1:0]    fwd_line,
    input  logic             rec_en,
    input  logic             rec_write,
    input  logic [LW-1:0]    rec_line,
    input  logic             clr,
    output logic             resp_valid,
    output logic             resp_nack,
    output logic [LINES-1:0] holds
);

    logic [LINES-1:0] rd_set;
    logic [LINES-1:0] wr_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_set <= '0;
            wr_set <= '0;
        end else begin
            if (clr) begin
                rd_set <= '0;
                wr_set <= '0;
            end
            if (rec_en) begin
                if (rec_write) wr_set[rec_line] <= 1'b1;
                else           rd_set[rec_line] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_nack  <= 1'b0;
        end else begin
            resp_valid <= fwd_hit;
            resp_nack  <= fwd_hit &&
                          tcd_conflict(fwd_write, rd_set[fwd_line], wr_set[fwd_line]);
        end
    end

    assign holds = rd_set | wr_set;

endmodule

// File: rtl/tcd_fsm.sv
module tcd_fsm
    import tcd_pkg::*;
#(
    parameter int NC = 4,
    parameter int CW = 2,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [CW-1:0] req_core,
    input  logic [LW-1:0] req_line,
    input  logic          req_write,
    input  logic          req_tx,
    input  logic [NC-1:0] target,
    input  logic [NC-1:0] resp_valid,
    input  logic [NC-1:0] resp_nack,
    output logic          req_ready,
    output logic          fwd_valid,
    output logic [NC-1:0] fwd_mask,
    output logic [CW-1:0] cur_core,
    output logic [LW-1:0] cur_line,
    output logic          cur_write,
    output logic          cur_tx,
    output logic          done_valid,
    output logic          done_grant
);

    typedef struct packed {
        logic [CW-1:0] core;
        logic [LW-1:0] line;
        logic          wr;
        logic          tx;
    } req_t;

    tcd_state_e    state;
    req_t          cur;
    logic [NC-1:0] pending;
    logic [NC-1:0] pending_next;
    logic          nack_acc;

    assign pending_next = pending & ~resp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            pending  <= '0;
            nack_acc <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur   <= '{core: req_core, line: req_line, wr: req_write, tx: req_tx};
                        state <= ST_FWD;
                    end
                end
                ST_FWD: begin
                    pending  <= target;
                    nack_acc <= 1'b0;
                    state    <= (target == '0) ? ST_RESP : ST_WAIT;
                end
                ST_WAIT: begin
                    pending <= pending_next;
                    if (|(resp_valid & resp_nack)) nack_acc <= 1'b1;
                    if (pending_next == '0) state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign fwd_valid  = (state == ST_FWD);
    assign fwd_mask   = fwd_valid ? target : '0;
    assign done_valid = (state == ST_RESP);
    assign done_grant = done_valid && !nack_acc;
    assign cur_core   = cur.core;
    assign cur_line   = cur.line;
    assign cur_write  = cur.wr;
    assign cur_tx     = cur.tx;

    AST_FWD_SKIPS_REQ: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !fwd_mask[cur.core]);                          // R2

    AST_NO_STRAY_REPLY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> ((resp_valid & ~pending) == '0));     // R5

    AST_NO_STRAY_REPLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (resp_valid == '0));                  // R5

    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(cur));                                // R9

endmodule

// File: rtl/txn_conflict_dir.sv
module txn_conflict_dir
    import tcd_pkg::*;
#(
    parameter int NC    = 4,
    parameter int LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [$clog2(NC)-1:0]    req_core,
    input  logic [$clog2(LINES)-1:0] req_line,
    input  logic                     req_write,
    input  logic                     req_tx,
    output logic                     req_ready,
    input  logic                     evict_valid,
    input  logic [$clog2(NC)-1:0]    evict_core,
    input  logic [$clog2(LINES)-1:0] evict_line,
    input  logic                     txend_valid,
    input  logic [$clog2(NC)-1:0]    txend_core,
    output logic                     fwd_valid,
    output logic [NC-1:0]            fwd_mask,
    output logic                     done_valid,
    output logic                     done_grant,
    output logic [$clog2(NC)-1:0]    done_core
);

    localparam int CW = $clog2(NC);
    localparam int LW = $clog2(LINES);

    logic [LINES-1:0][NC-1:0] sharers, sharers_n;
    logic [LINES-1:0][NC-1:0] sticky,  sticky_n;
    logic [NC-1:0][LINES-1:0] holds;
    logic [NC-1:0]            target, resp_valid, resp_nack;
    logic [CW-1:0]            cur_core;
    logic [LW-1:0]            cur_line;
    logic                     cur_write, cur_tx;
    logic [NC-1:0]            req_bit, ev_bit, te_bit;

    assign req_bit = NC'(1) << cur_core;
    assign ev_bit  = NC'(1) << evict_core;
    assign te_bit  = NC'(1) << txend_core;
    assign target  = (sharers[cur_line] | sticky[cur_line]) & ~req_bit;

    tcd_fsm #(.NC(NC), .CW(CW), .LW(LW)) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_core(req_core), .req_line(req_line),
        .req_write(req_write), .req_tx(req_tx),
        .target(target), .resp_valid(resp_valid), .resp_nack(resp_nack),
        .req_ready(req_ready), .fwd_valid(fwd_valid), .fwd_mask(fwd_mask),
        .cur_core(cur_core), .cur_line(cur_line), .cur_write(cur_write), .cur_tx(cur_tx),
        .done_valid(done_valid), .done_grant(done_grant)
    );

    assign done_core = cur_core;

    for (genvar c = 0; c < NC; c++) begin : g_core
        tcd_core_sets #(.LINES(LINES), .LW(LW)) u_sets (
            .clk(clk), .rst(rst),
            .fwd_hit(fwd_mask[c]), .fwd_write(cur_write), .fwd_line(cur_line),
            .rec_en(done_grant && cur_tx && (cur_core == CW'(c))),
            .rec_write(cur_write), .rec_line(cur_line),
            .clr(txend_valid && (txend_core == CW'(c))),
            .resp_valid(resp_valid[c]), .resp_nack(resp_nack[c]),
            .holds(holds[c])
        );
    end

    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            sharers_n[l] = sharers[l];
            sticky_n[l]  = sticky[l];
            if (done_grant && cur_line == LW'(l))
                sharers_n[l] = cur_write ? req_bit : (sharers[l] | req_bit);
            if (evict_valid && evict_line == LW'(l)) begin
                sharers_n[l] = sharers_n[l] & ~ev_bit;
                if (holds[evict_core][l]) sticky_n[l] = sticky_n[l] | ev_bit;
            end
            if (txend_valid) sticky_n[l] = sticky_n[l] & ~te_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sharers <= '0;
            sticky  <= '0;
        end else begin
            sharers <= sharers_n;
            sticky  <= sticky_n;
        end
    end

    AST_REFUSE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_grant && !evict_valid && !txend_valid)
        |=> ($stable(sharers) && $stable(sticky)));                   // R4

    AST_WRITE_SOLE_SHARER: assert property (@(posedge clk) disable iff (rst)
        (done_grant && cur_write && !evict_valid)
        |=> (sharers[cur_line] == (NC'(1) << cur_core)));             // R6

    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (rst)
        !txend_valid |=> ((sticky & $past(sticky)) == $past(sticky))); // R7

endmodule

// File: tb/txn_conflict_dir_bench.sv
module txn_conflict_dir_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, req_tx = 1'b0;
    logic [1:0] req_core = '0, evict_core = '0, txend_core = '0;
    logic [2:0] req_line = '0, evict_line = '0;
    logic       evict_valid = 1'b0, txend_valid = 1'b0;
    logic       req_ready, fwd_valid, done_valid, done_grant;
    logic [3:0] fwd_mask;
    logic [1:0] done_core;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    txn_conflict_dir #(.NC(4), .LINES(8)) u_txn_conflict_dir (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_core(req_core), .req_line(req_line),
        .req_write(req_write), .req_tx(req_tx), .req_ready(req_ready),
        .evict_valid(evict_valid), .evict_core(evict_core), .evict_line(evict_line),
        .txend_valid(txend_valid), .txend_core(txend_core),
        .fwd_valid(fwd_valid), .fwd_mask(fwd_mask),
        .done_valid(done_valid), .done_grant(done_grant), .done_core(done_core)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_req(input int c, input int l, input int w, input int t,
                          output int fm, output int g, output int lat, output int dc);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_core = 2'(c); req_line = 3'(l);
        req_write = w[0]; req_tx = t[0];
        @(negedge clk);
        req_valid = 1'b0;
        fm = fwd_valid ? int'(fwd_mask) : -1;
        lat = 0; n = 0;
        while (!done_valid && n < 50) begin
            @(negedge clk);
            lat++; n++;
        end
        g = int'(done_grant);
        dc = int'(done_core);
    endtask

    task automatic do_evict(input int c, input int l);
        @(negedge clk);
        evict_valid = 1'b1; evict_core = 2'(c); evict_line = 3'(l);
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic do_txend(input int c);
        @(negedge clk);
        txend_valid = 1'b1; txend_core = 2'(c);
        @(negedge clk);
        txend_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fm, g, lat, dc;
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", "req_ready after reset", int'(req_ready), 1);
        check("R1", "done_valid after reset", int'(done_valid), 0);
        check("R1", "fwd_valid after reset", int'(fwd_valid), 0);
        do_req(0, 0, 1, 1, fm, g, lat, dc);
        check("R1", "first request mask", fm, 0);
        check("R1", "first request grant", g, 1);

        // Sweep: requester r, other core o with footprint s (0 none, 1 read, 2 write), op w
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < 4; o++) begin
                if (o == r) continue;
                for (int s = 0; s < 3; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        int exp_fm, exp_g;
                        do_reset();
                        if (s > 0) begin
                            do_req(o, 3, (s == 2) ? 1 : 0, 1, fm, g, lat, dc);
                            check("R10", "setup grant", g, 1);
                        end
                        exp_fm = (s > 0) ? (1 << o) : 0;
                        exp_g  = (s == 2 || (w == 1 && s == 1)) ? 0 : 1;
                        do_req(r, 3, w, 0, fm, g, lat, dc);
                        check("R2", "forward mask", fm, exp_fm);
                        check("R3", "decision", g, exp_g);
                        check("R5", "latency", lat, (exp_fm != 0) ? 2 : 1);
                        check("R5", "done core", dc, r);
                        if (exp_g == 0) begin
                            do_req(r, 3, w, 0, fm, g, lat, dc);
                            check("R4", "repeat mask after refusal", fm, exp_fm);
                            check("R4", "repeat refusal", g, 0);
                        end else if (w == 1) begin
                            do_req(o, 3, 0, 0, fm, g, lat, dc);
                            check("R6", "mask after granted write", fm, 1 << r);
                            check("R6", "read after write grant", g, 1);
                        end
                    end
                end
            end
        end

        // R6: read sharers accumulate, write replaces them
        do_reset();
        do_req(0, 1, 0, 0, fm, g, lat, dc);
        do_req(1, 1, 0, 0, fm, g, lat, dc);
        check("R6", "second reader mask", fm, 4'b0001);
        do_req(2, 1, 1, 0, fm, g, lat, dc);
        check("R6", "writer mask over readers", fm, 4'b0011);
        check("R6", "writer grant", g, 1);
        do_req(0, 1, 0, 0, fm, g, lat, dc);
        check("R6", "mask after write", fm, 4'b0100);

        // R7 / R8: transactional eviction leaves a sticky holder
        do_reset();
        do_req(1, 5, 0, 1, fm, g, lat, dc);
        do_evict(1, 5);
        do_req(2, 5, 0, 0, fm, g, lat, dc);
        check("R7", "sticky forwarded on read", fm, 4'b0010);
        check("R7", "read vs sticky read set", g, 1);
        do_req(2, 5, 1, 0, fm, g, lat, dc);
        check("R7", "sticky forwarded on write", fm, 4'b0010);
        check("R7", "write vs sticky read set", g, 0);
        do_txend(1);
        do_req(2, 5, 1, 0, fm, g, lat, dc);
        check("R8", "mask after txend", fm, 0);
        check("R8", "grant after txend", g, 1);
        // R7: non-transactional eviction drops the core
        do_req(3, 6, 0, 0, fm, g, lat, dc);
        do_evict(3, 6);
        do_req(0, 6, 1, 0, fm, g, lat, dc);
        check("R7", "mask after plain eviction", fm, 0);
        check("R7", "grant after plain eviction", g, 1);

        // R10: non-transactional write leaves no set bit
        do_reset();
        do_req(0, 2, 1, 0, fm, g, lat, dc);
        do_req(1, 2, 0, 0, fm, g, lat, dc);
        check("R10", "mask to plain writer", fm, 4'b0001);
        check("R10", "read vs plain writer", g, 1);

        // R9: a request held while busy is ignored
        do_reset();
        @(negedge clk);
        req_valid = 1'b1; req_core = 2'd1; req_line = 3'd4; req_write = 1'b1; req_tx = 1'b1;
        @(negedge clk);
        check("R9", "ready while busy", int'(req_ready), 0);
        req_core = 2'd2; req_write = 1'b1; req_tx = 1'b1;
        while (!done_valid) @(negedge clk);
        req_valid = 1'b0;
        check("R9", "done core of accepted request", int'(done_core), 1);
        check("R9", "accepted request grant", int'(done_grant), 1);
        do_req(2, 4, 0, 0, fm, g, lat, dc);
        check("R9", "mask shows only first writer", fm, 4'b0010);
        check("R9", "read refused by first writer", g, 0);
        do_req(3, 4, 0, 0, fm, g, lat, dc);
        check("R9", "no trace of ignored request", fm, 4'b0010);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule